// File: doc/BRIEF.md
# Serial link break detector

This block watches a two-wire clocked serial link: a link clock and a data line whose electrical level is inverted. It detects the master's break condition, which resets the link. Only the master can send a break, so data is sampled on rising link-clock edges only. Both link wires first pass through a two-flop synchronizer, and rising edges are found in the system clock domain.

The block counts consecutive logical-one samples. When the count reaches the break length, it emits a one-cycle break pulse. In the same cycle it emits a one-cycle pulse that tells the neighbouring frame logic to clear its per-slave address-valid flags, its busy-sequence count and its valid-response flag. It then holds the link out of idle for a short turnaround, counted in rising link-clock edges. If the asserted level lasts past the break length, a one-cycle warning pulse follows when the level finally drops. The run counter saturates, so a break of any length cannot wrap it.

Top module: `link_break_detector`

## Requirements
- R1: After the active-low reset, break_detected, break_overlong and history_clear are 0 and link_idle is 1.
- R2: The data wire is inverted: a low level on lnk_dat_n is a logical 1 and a high level is a logical 0.
- R3: Data is sampled only at rising edges of lnk_clk. A level that is present only while lnk_clk is low has no effect.
- R4: break_detected pulses high for exactly one system clock cycle at the rising edge that samples the 256th consecutive logical 1.
- R5: A logical 0 sample restarts the count, so 255 consecutive ones produce no break.
- R6: history_clear pulses for one cycle in the same cycle as break_detected, and at no other time.
- R7: link_idle goes low with the break pulse. It returns high on the 4th rising link-clock edge after the break edge, because the turnaround counter must exceed 3.
- R8: break_overlong pulses for one cycle when a logical 0 is sampled after 257 or more consecutive ones. A run of exactly 256 ones gives no warning.
- R9: The run counter saturates. A break of any length, for example 600 ones, yields exactly one break pulse and one overlong pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_clk | input | 1 | Link clock, asynchronous to clk |
| lnk_dat_n | input | 1 | Link data, electrically inverted |
| break_detected | output | 1 | One-cycle pulse when a break is recognised |
| break_overlong | output | 1 | One-cycle warning pulse when a break that ran too long ends |
| history_clear | output | 1 | One-cycle pulse that clears the frame logic's per-slave history |
| link_idle | output | 1 | High when the link is free; low during the post-break turnaround |

## Verification
Runs of ones of length 255, 256, 257, 300 and 600, each followed by zeros, separate the break threshold from the overlong threshold. They also show that the counter saturates without wrapping. A run cut by a single zero and a run cut by reset show that only consecutive samples count. Ones placed only in the low phase of the link clock show that falling-edge data is ignored. A step-by-step walk through the turnaround places link_idle's return on exactly the 4th rising edge after the break.

// File: rtl/link_break_detector.sv
module link_break_detector #(
  parameter int BREAK_LEN  = 256,
  parameter int TURN_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lnk_clk,
  input  logic lnk_dat_n,
  output logic break_detected,
  output logic break_overlong,
  output logic history_clear,
  output logic link_idle
);
  localparam int RUN_MAX = BREAK_LEN + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int TURN_W  = $clog2(TURN_EDGES + 1);
  localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0]  RUN_HIT  = RUN_W'(BREAK_LEN - 1);
  localparam logic [TURN_W-1:0] TURN_END = TURN_W'(TURN_EDGES);

  logic [1:0]        clk_sy, dat_sy;
  logic              clk_q;
  logic [RUN_W-1:0]  run;
  logic [TURN_W-1:0] turn;

  wire rise    = clk_sy[1] & ~clk_q;
  wire bit_one = ~dat_sy[1];
  wire hit     = rise & bit_one & (run == RUN_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sy         <= 2'b00;
      dat_sy         <= 2'b11;
      clk_q          <= 1'b0;
      run            <= '0;
      turn           <= '0;
      break_detected <= 1'b0;
      break_overlong <= 1'b0;
      history_clear  <= 1'b0;
      link_idle      <= 1'b1;
    end else begin
      clk_sy         <= {clk_sy[0], lnk_clk};
      dat_sy         <= {dat_sy[0], lnk_dat_n};
      clk_q          <= clk_sy[1];
      break_detected <= hit;
      history_clear  <= hit;
      break_overlong <= rise & ~bit_one & (run == RUN_TOP);
      if (rise) begin
        if (!bit_one)            run <= '0;
        else if (run != RUN_TOP) run <= run + 1'b1;
      end
      if (hit) begin
        link_idle <= 1'b0;
        turn      <= '0;
      end else if (rise && !link_idle) begin
        if (turn == TURN_END) link_idle <= 1'b1;
        else                  turn      <= turn + 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_break_detector_chk.sv
module link_break_detector_chk #(
  parameter int RUN_MAX = 257,
  parameter int RUN_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             break_detected,
  input logic             break_overlong,
  input logic             history_clear,
  input logic             link_idle,
  input logic [RUN_W-1:0] run
);
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    break_detected |=> !break_detected);
  p_clear_with_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    history_clear == break_detected);
  p_busy_after_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    break_detected |-> !link_idle);
  p_warn_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    break_overlong |=> !break_overlong);
  p_warn_not_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    break_overlong |-> !break_detected);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(RUN_MAX));
endmodule

bind link_break_detector link_break_detector_chk #(.RUN_MAX(RUN_MAX), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .break_detected(break_detected),
  .break_overlong(break_overlong), .history_clear(history_clear),
  .link_idle(link_idle), .run(run)
);

// File: tb/link_break_detector_tb_top.sv
module link_break_detector_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, lnk_clk = 1'b0, lnk_dat_n = 1'b1;
  logic break_detected, break_overlong, history_clear, link_idle;
  int checks = 0, failures = 0;
  int n_brk = 0, n_ovl = 0, n_hc = 0;

  always #4 clk = ~clk;

  link_break_detector dut_i (
    .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_dat_n(lnk_dat_n),
    .break_detected(break_detected), .break_overlong(break_overlong),
    .history_clear(history_clear), .link_idle(link_idle)
  );

  always @(negedge clk) begin
    if (break_detected) n_brk++;
    if (break_overlong) n_ovl++;
    if (history_clear)  n_hc++;
  end

  // each row: ones in the run, expected breaks, expected overlong warnings
  localparam int VEC [5][3] = '{'{255,0,0}, '{256,1,0}, '{257,1,1}, '{300,1,1}, '{600,1,1}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic val, input logic low_glitch);
    lnk_clk = 1'b0;
    lnk_dat_n = ~(low_glitch | val);
    repeat (3) @(posedge clk);
    lnk_dat_n = ~val;
    @(posedge clk);
    lnk_clk = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic send_run(input int n, input logic val);
    for (int i = 0; i < n; i++) send_bit(val, 1'b0);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    n_brk = 0; n_ovl = 0; n_hc = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 break_detected", int'(break_detected), 0);
    chk("R1 break_overlong", int'(break_overlong), 0);
    chk("R1 history_clear", int'(history_clear), 0);
    chk("R1 link_idle", int'(link_idle), 1);

    for (int v = 0; v < 5; v++) begin
      clear_counts();
      send_run(VEC[v][0], 1'b1);
      send_run(8, 1'b0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R4 R5 R9 breaks for %0d ones", VEC[v][0]), n_brk, VEC[v][1]);
      chk($sformatf("R8 R9 warnings for %0d ones", VEC[v][0]), n_ovl, VEC[v][2]);
      chk($sformatf("R6 clears for %0d ones", VEC[v][0]), n_hc, VEC[v][1]);
      chk($sformatf("R7 idle after %0d ones", VEC[v][0]), int'(link_idle), 1);
    end

    // R7: step through the turnaround
    clear_counts();
    send_run(256, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 low after break", int'(link_idle), 0);
    chk("R2 low wire level counted as one", n_brk, 1);
    send_run(3, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 still low after 3 edges", int'(link_idle), 0);
    send_run(1, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 high after 4th edge", int'(link_idle), 1);
    send_run(4, 1'b0);

    // R5: a single zero restarts the run
    clear_counts();
    send_run(200, 1'b1);
    send_run(1, 1'b0);
    send_run(200, 1'b1);
    send_run(4, 1'b0);
    chk("R5 split run no break", n_brk, 0);

    // R1: reset discards a partial run
    clear_counts();
    send_run(200, 1'b1);
    do_reset();
    send_run(100, 1'b1);
    send_run(4, 1'b0);
    chk("R1 reset clears run", n_brk, 0);

    // R3: ones present only while the link clock is low
    clear_counts();
    for (int i = 0; i < 300; i++) send_bit(1'b0, 1'b1);
    send_run(4, 1'b0);
    chk("R3 low-phase ones ignored", n_brk, 0);
    chk("R3 link stays idle", int'(link_idle), 1);

    // R2: high wire level is logical zero
    clear_counts();
    send_run(300, 1'b0);
    chk("R2 high wire level no break", n_brk, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule